// File: doc/BRIEF.md
# Four-Level Page Table Walker

This block translates a 48-bit virtual address into a 52-bit physical address. It does this by reading 64-bit descriptors from a radix tree of four tables held in memory. A requester hands it one virtual address at a time, together with an access kind (read, write or instruction fetch) and a privilege flag (user or supervisor). The walk starts at a root table whose 4 KB frame number is supplied on a separate input. Each table lookup is sent as a physical 64-bit read over a valid/ready memory port. That port returns exactly one response beat for every request it accepts.

Before any table read, the block checks that the upper bits of the virtual address are a sign extension of bit 47. During the walk it carries three permissions down the tree, and the most restrictive value wins: writable, user-accessible and no-execute. A page-size flag in the second-level or third-level descriptor ends the walk early and maps a 1 GB or 2 MB page. A successful walk may need to set the accessed bit, or the dirty bit on a write. The block then writes the updated terminal descriptor back to memory with a single 64-bit store. This store happens before the result is offered. The result is either a physical address with page size and permissions, or a fault code with the level at which the walk stopped.

Top module: `ptw_walker`

## Requirements
- R1: Bits 63..48 of the request address must all equal bit 47. Otherwise the response carries fault code 1 (non-canonical) and level 0, and no memory request of any kind is issued. A high-half address that is correctly sign-extended is walked normally.
- R2: Level N (1..4) uses the virtual index field in bits 47..39, 38..30, 29..21 or 20..12 respectively. It reads (write-enable 0) from the physical address {table frame, index, 3'b000}. The level-1 table frame is the root input, and each deeper frame is bits 51..12 of the previous descriptor.
- R3: A descriptor with bit 0 clear ends the walk at once. The response has fault code 2 (not present) and the level of that descriptor. No further read and no write-back follow.
- R4: The reported permissions accumulate over every visited descriptor. Writable is the AND of bit 1, user is the AND of bit 2, and no-execute is the OR of bit 63. They are valid on responses with fault code 0.
- R5: Protection is checked against the terminal descriptor's accumulated permissions. A write (access code 1) without writable fails. A user request without user permission fails. A fetch (access code 2) with no-execute fails. A failure gives fault code 3 with the terminal level and no write-back. Supervisor requests may use user pages. Read is access code 0.
- R6: Bit 7 set in a level-2 descriptor ends the walk with size code 2 (1 GB): address = descriptor bits 51..30 joined with virtual bits 29..0. Bit 7 set at level 3 gives size code 1 (2 MB): descriptor bits 51..21 joined with virtual bits 20..0. Bit 7 has no effect at levels 1 and 4.
- R7: A four-level walk gives size code 0, level 4, and address = descriptor bits 51..12 joined with virtual bits 11..0.
- R8: On success the terminal descriptor is updated with bit 5 (accessed) set, and on a write also bit 6 (dirty). It is stored with one write to that descriptor's address, but only if this changes it. The store completes before the response is offered.
- R9: Only one walk is in flight. req_ready is high only while idle, so it goes low after acceptance. Once raised, a response holds its values until rsp_ready completes the handshake.
- R10: A memory request that is not yet accepted stays valid with unchanged address and write-enable until mem_req_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_va | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| req_user | input | 1 | 1 for a user-level request |
| root_frame | input | 40 | 4 KB frame number of the level-1 table |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_we | output | 1 | 1 for the descriptor write-back |
| mem_req_addr | output | 52 | Physical byte address of the descriptor |
| mem_req_wdata | output | 64 | Updated descriptor for write-back |
| mem_rsp_valid | input | 1 | One beat per accepted memory request |
| mem_rsp_data | input | 64 | Descriptor read data |
| rsp_valid | output | 1 | Translation result valid |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_pa | output | 52 | Translated physical address |
| rsp_size | output | 2 | 0 = 4 KB, 1 = 2 MB, 2 = 1 GB |
| rsp_fault | output | 2 | 0 none, 1 non-canonical, 2 not present, 3 protection |
| rsp_level | output | 3 | Level where the walk ended (0 for non-canonical) |
| rsp_wr | output | 1 | Accumulated writable |
| rsp_user | output | 1 | Accumulated user access |
| rsp_nx | output | 1 | Accumulated no-execute |

## Verification
Some properties are checked on every clock by the assertions. Memory and result handshakes hold steady under backpressure. A walk never issues more than four reads or more than one store. A non-canonical request touches no memory, and a faulting walk never writes back. The store changes only the accessed and dirty bits, and the reported level matches the page size.

Other behaviour needs concrete table contents, so only the bench scenarios can show it. This covers the exact descriptor addresses, the physical address for each page size, the accumulation of permissions across levels, and bit 7 having no effect at levels 1 and 4. It also covers whether a store happens or not, and what the descriptor holds in memory afterwards.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W    = 48;
  localparam int PA_W    = 52;
  localparam int ENT_W   = 64;
  localparam int IDX_W   = 9;
  localparam int OFF_W   = 12;
  localparam int LEVELS  = 4;
  localparam int LVL_W   = $clog2(LEVELS);
  localparam int FRAME_W = PA_W - OFF_W;
  localparam int SLOT_W  = OFF_W - IDX_W;
  localparam int HUGE_LO = LEVELS - 3;
  localparam int HUGE_HI = LEVELS - 2;

  localparam int BIT_P  = 0;
  localparam int BIT_W  = 1;
  localparam int BIT_U  = 2;
  localparam int BIT_A  = 5;
  localparam int BIT_D  = 6;
  localparam int BIT_PS = 7;
  localparam int BIT_NX = 63;

  localparam logic [ENT_W-1:0] A_MASK = ENT_W'(1) << BIT_A;
  localparam logic [ENT_W-1:0] D_MASK = ENT_W'(1) << BIT_D;

  typedef enum logic [1:0] {ACC_READ = 2'd0, ACC_WRITE = 2'd1, ACC_FETCH = 2'd2} acc_e;
  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_NONCANON = 2'd1,
                            FLT_NOTPRES = 2'd2, FLT_PROT = 2'd3} fault_e;

  // index field of the virtual address used at a given level (0 = root)
  function automatic logic [IDX_W-1:0] va_index(input logic [VA_W-1:0] va,
                                                input logic [LVL_W-1:0] lvl);
    int sh;
    sh = OFF_W + IDX_W * (LEVELS - 1 - int'(lvl));
    return IDX_W'(va >> sh);
  endfunction

  // byte address of a descriptor: frame base plus index scaled by 8
  function automatic logic [PA_W-1:0] slot_addr(input logic [FRAME_W-1:0] frame,
                                                input logic [IDX_W-1:0] idx);
    return {frame, idx, {SLOT_W{1'b0}}};
  endfunction

  // join the terminal frame bits with the untranslated offset
  function automatic logic [PA_W-1:0] join_pa(input logic [PA_W-1:0] ent,
                                              input logic [VA_W-1:0] va,
                                              input logic [1:0] size);
    int ob;
    logic [PA_W-1:0] keep;
    ob   = OFF_W + IDX_W * int'(size);
    keep = (PA_W'(1) << ob) - PA_W'(1);
    return (ent & ~keep) | (PA_W'(va) & keep);
  endfunction
endpackage

// File: rtl/ptw_canon.sv
module ptw_canon
  import ptw_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] va,
  output logic              canon_ok
);
  localparam int TOP_W = ADDR_W - VA_W + 1;
  logic [TOP_W-1:0] top_bits;
  assign top_bits = va[ADDR_W-1:VA_W-1];
  assign canon_ok = (&top_bits) | ~(|top_bits);
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
(
  input  logic             bit_p,
  input  logic             bit_w,
  input  logic             bit_u,
  input  logic             bit_ps,
  input  logic             bit_nx,
  input  logic [LVL_W-1:0] lvl,
  input  logic [1:0]       acc,
  input  logic             user,
  input  logic             wr_in,
  input  logic             usr_in,
  input  logic             nx_in,
  output logic             present,
  output logic             leaf,
  output logic [1:0]       size,
  output logic             wr_out,
  output logic             usr_out,
  output logic             nx_out,
  output logic             prot
);
  logic huge_lvl;
  assign present  = bit_p;
  assign huge_lvl = (lvl >= LVL_W'(HUGE_LO)) && (lvl <= LVL_W'(HUGE_HI));
  assign leaf     = (lvl == LVL_W'(LEVELS - 1)) || (bit_ps && huge_lvl);
  assign size     = 2'(LVL_W'(LEVELS - 1) - lvl);
  assign wr_out   = wr_in & bit_w;
  assign usr_out  = usr_in & bit_u;
  assign nx_out   = nx_in | bit_nx;
  assign prot     = leaf && (((acc == ACC_WRITE) && !wr_out) ||
                             (user && !usr_out) ||
                             ((acc == ACC_FETCH) && nx_out));
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
  import ptw_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [63:0]        req_va,
  input  logic [1:0]         req_acc,
  input  logic               req_user,
  input  logic [FRAME_W-1:0] root_frame,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_we,
  output logic [PA_W-1:0]    mem_req_addr,
  output logic [ENT_W-1:0]   mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [PA_W-1:0]    rsp_pa,
  output logic [1:0]         rsp_size,
  output logic [1:0]         rsp_fault,
  output logic [2:0]         rsp_level,
  output logic               rsp_wr,
  output logic               rsp_user,
  output logic               rsp_nx
);
  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_RWAIT, ST_WBACK, ST_WWAIT, ST_RESP} st_e;

  st_e               state_q;
  logic [VA_W-1:0]   va_q;
  logic [1:0]        acc_q;
  logic              user_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [FRAME_W-1:0] base_q;
  logic [PA_W-1:0]   ent_addr_q;
  logic [ENT_W-1:0]  entry_q;
  logic [ENT_W-1:0]  raw_q;
  logic              wr_q, usr_q, nx_q;
  logic [PA_W-1:0]   pa_q;
  logic [1:0]        size_q;
  fault_e            fault_q;
  logic [2:0]        level_q;
  logic [2:0]        rd_cnt_q, wb_cnt_q;

  // named internal events
  logic walk_start, rd_fire, wb_fire, ent_take, rsp_fire;
  logic canon_ok;
  logic [PA_W-1:0] rd_addr_c;
  logic [ENT_W-1:0] upd_c;
  logic need_wb_c;
  logic ev_present, ev_leaf, ev_wr, ev_usr, ev_nx, ev_prot;
  logic [1:0] ev_size;

  assign walk_start = req_valid && req_ready;
  assign rd_fire    = (state_q == ST_READ)  && mem_req_ready;
  assign wb_fire    = (state_q == ST_WBACK) && mem_req_ready;
  assign ent_take   = (state_q == ST_RWAIT) && mem_rsp_valid;
  assign rsp_fire   = rsp_valid && rsp_ready;

  ptw_canon #(.ADDR_W(64)) u_canon (.va(req_va), .canon_ok(canon_ok));

  ptw_entry_eval u_eval (
    .bit_p  (mem_rsp_data[BIT_P]),
    .bit_w  (mem_rsp_data[BIT_W]),
    .bit_u  (mem_rsp_data[BIT_U]),
    .bit_ps (mem_rsp_data[BIT_PS]),
    .bit_nx (mem_rsp_data[BIT_NX]),
    .lvl    (lvl_q),
    .acc    (acc_q),
    .user   (user_q),
    .wr_in  (wr_q),
    .usr_in (usr_q),
    .nx_in  (nx_q),
    .present(ev_present),
    .leaf   (ev_leaf),
    .size   (ev_size),
    .wr_out (ev_wr),
    .usr_out(ev_usr),
    .nx_out (ev_nx),
    .prot   (ev_prot)
  );

  assign rd_addr_c = slot_addr(base_q, va_index(va_q, lvl_q));
  assign upd_c     = mem_rsp_data | A_MASK | ((acc_q == ACC_WRITE) ? D_MASK : '0);
  assign need_wb_c = (upd_c != mem_rsp_data);

  assign req_ready     = (state_q == ST_IDLE);
  assign mem_req_valid = (state_q == ST_READ) || (state_q == ST_WBACK);
  assign mem_req_we    = (state_q == ST_WBACK);
  assign mem_req_addr  = (state_q == ST_WBACK) ? ent_addr_q : rd_addr_c;
  assign mem_req_wdata = entry_q;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_pa        = pa_q;
  assign rsp_size      = size_q;
  assign rsp_fault     = fault_q;
  assign rsp_level     = level_q;
  assign rsp_wr        = wr_q;
  assign rsp_user      = usr_q;
  assign rsp_nx        = nx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      acc_q      <= '0;
      user_q     <= 1'b0;
      lvl_q      <= '0;
      base_q     <= '0;
      ent_addr_q <= '0;
      entry_q    <= '0;
      raw_q      <= '0;
      wr_q       <= 1'b0;
      usr_q      <= 1'b0;
      nx_q       <= 1'b0;
      pa_q       <= '0;
      size_q     <= '0;
      fault_q    <= FLT_NONE;
      level_q    <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (walk_start) begin
          va_q    <= req_va[VA_W-1:0];
          acc_q   <= req_acc;
          user_q  <= req_user;
          lvl_q   <= '0;
          base_q  <= root_frame;
          wr_q    <= 1'b1;
          usr_q   <= 1'b1;
          nx_q    <= 1'b0;
          pa_q    <= '0;
          size_q  <= '0;
          level_q <= '0;
          if (!canon_ok) begin
            fault_q <= FLT_NONCANON;
            state_q <= ST_RESP;
          end else begin
            fault_q <= FLT_NONE;
            state_q <= ST_READ;
          end
        end
        ST_READ: if (rd_fire) begin
          ent_addr_q <= rd_addr_c;
          state_q    <= ST_RWAIT;
        end
        ST_RWAIT: if (ent_take) begin
          if (!ev_present) begin
            fault_q <= FLT_NOTPRES;
            level_q <= 3'(lvl_q) + 3'd1;
            state_q <= ST_RESP;
          end else begin
            wr_q  <= ev_wr;
            usr_q <= ev_usr;
            nx_q  <= ev_nx;
            if (!ev_leaf) begin
              base_q  <= mem_rsp_data[PA_W-1:OFF_W];
              lvl_q   <= lvl_q + 1'b1;
              state_q <= ST_READ;
            end else if (ev_prot) begin
              fault_q <= FLT_PROT;
              level_q <= 3'(lvl_q) + 3'd1;
              state_q <= ST_RESP;
            end else begin
              pa_q    <= join_pa(mem_rsp_data[PA_W-1:0], va_q, ev_size);
              size_q  <= ev_size;
              level_q <= 3'(lvl_q) + 3'd1;
              entry_q <= upd_c;
              raw_q   <= mem_rsp_data;
              state_q <= need_wb_c ? ST_WBACK : ST_RESP;
            end
          end
        end
        ST_WBACK: if (wb_fire) state_q <= ST_WWAIT;
        ST_WWAIT: if (mem_rsp_valid) state_q <= ST_RESP;
        ST_RESP:  if (rsp_fire) state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  // per-walk memory traffic counters for the assertions
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt_q <= '0;
      wb_cnt_q <= '0;
    end else if (walk_start) begin
      rd_cnt_q <= '0;
      wb_cnt_q <= '0;
    end else begin
      if (rd_fire) rd_cnt_q <= rd_cnt_q + 3'd1;
      if (wb_fire) wb_cnt_q <= wb_cnt_q + 3'd1;
    end
  end

  // R1
  canon_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONCANON) |-> (rd_cnt_q == 3'd0 && wb_cnt_q == 3'd0));

  // R2
  depth_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt_q <= 3'(LEVELS));

  // R5
  fault_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != FLT_NONE) |-> (wb_cnt_q == 3'd0));

  // R6
  size_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault == FLT_NONE) |-> (rsp_level == 3'(LEVELS) - 3'(rsp_size)));

  // R8
  single_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_cnt_q <= 3'd1);

  // R8
  store_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |->
      (((mem_req_wdata ^ raw_q) & ~(A_MASK | D_MASK)) == '0 && mem_req_wdata[BIT_A]));

  // R9
  one_walk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    walk_start |=> !req_ready);

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_pa) && $stable(rsp_fault) && $stable(rsp_level)));

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we)));
endmodule

// File: tb/test_ptw_walker.sv
module test_ptw_walker;
  import ptw_pkg::*;

  typedef struct {
    logic [51:0] pa;
    logic [1:0]  size;
    logic [1:0]  fault;
    logic [2:0]  lvl;
    logic        wr, usr, nx;
    int          reads, writes;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_va = '0;
  logic [1:0]  req_acc = '0;
  logic        req_user = 1'b0;
  logic [39:0] root_frame;
  logic        mem_req_valid, mem_req_ready, mem_req_we;
  logic [51:0] mem_req_addr;
  logic [63:0] mem_req_wdata;
  logic        mem_rsp_valid;
  logic [63:0] mem_rsp_data;
  logic        rsp_valid, rsp_ready;
  logic [51:0] rsp_pa;
  logic [1:0]  rsp_size, rsp_fault;
  logic [2:0]  rsp_level;
  logic        rsp_wr, rsp_user, rsp_nx;

  localparam logic [51:0] ROOT = 52'h10000;
  localparam logic [51:0] T2   = 52'h20000;
  localparam logic [51:0] T3   = 52'h30000;
  localparam logic [51:0] T4   = 52'h40000;
  localparam logic [51:0] F1   = 52'h0_0001_2345_6000;
  localparam logic [51:0] F2   = 52'h0_0000_ABCD_E000;
  localparam logic [51:0] F3   = 52'h0_0000_5555_5000;
  localparam logic [63:0] E1G  = 64'h0000_00C0_4001_2087;
  localparam logic [63:0] E2M  = 64'h8000_0000_1260_00A7;
  localparam logic [63:0] E1G2 = 64'h0000_0001_4000_00A7;

  assign root_frame = ROOT[51:12];

  always #5 clk = ~clk;

  ptw_walker i_ptw_walker (.*);

  logic [63:0] mem [logic [51:0]];
  logic [51:0] rd_log [$];
  exp_t        exq [$];
  int n_chk = 0, n_fail = 0, n_rd = 0, n_wr = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mrd(input logic [51:0] a);
    return mem.exists(a) ? mem[a] : 64'd0;
  endfunction

  function automatic logic [51:0] slot(input logic [51:0] base, input int idx);
    return base + 52'(idx * 8);
  endfunction

  task automatic put(input logic [51:0] base, input int idx, input logic [63:0] v);
    mem[slot(base, idx)] = v;
  endtask

  function automatic logic [63:0] mkva(input int a, input int b, input int c, input int d, input int off);
    logic [47:0] v;
    v = {a[8:0], b[8:0], c[8:0], d[8:0], off[11:0]};
    return {{16{v[47]}}, v};
  endfunction

  function automatic exp_t ok_e(input string tag, input logic [51:0] pa, input logic [1:0] size,
                                input logic [2:0] lvl, input logic wr, input logic usr, input logic nx,
                                input int reads, input int writes);
    exp_t e;
    e.tag = tag; e.pa = pa; e.size = size; e.fault = 2'd0; e.lvl = lvl;
    e.wr = wr; e.usr = usr; e.nx = nx; e.reads = reads; e.writes = writes;
    return e;
  endfunction

  function automatic exp_t flt_e(input string tag, input logic [1:0] fault, input logic [2:0] lvl,
                                 input int reads);
    exp_t e;
    e.tag = tag; e.pa = '0; e.size = '0; e.fault = fault; e.lvl = lvl;
    e.wr = 1'b0; e.usr = 1'b0; e.nx = 1'b0; e.reads = reads; e.writes = 0;
    return e;
  endfunction

  // memory model: variable stalls, one response beat per accepted request
  initial begin : memory_model
    bit pend = 0;
    logic [63:0] pend_data = '0;
    int stall = 0;
    bit stalled = 0;
    logic [51:0] held_addr = '0;
    logic held_we = 1'b0;
    mem_req_ready = 1'b0;
    mem_rsp_valid = 1'b0;
    mem_rsp_data  = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = pend;
      mem_rsp_data  = pend ? pend_data : 64'd0;
      pend = 0;
      if (stalled && rst_n)
        chk(mem_req_valid && mem_req_addr == held_addr && mem_req_we == held_we,
            "R10 stalled request held", {11'd0, mem_req_we, mem_req_addr}, {11'd0, held_we, held_addr});
      stall++;
      mem_req_ready = (stall % 3) != 0;
      stalled = mem_req_valid && !mem_req_ready;
      held_addr = mem_req_addr;
      held_we = mem_req_we;
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          mem[mem_req_addr] = mem_req_wdata;
          n_wr++;
          pend_data = '0;
        end else begin
          pend_data = mrd(mem_req_addr);
          rd_log.push_back(mem_req_addr);
          n_rd++;
        end
        pend = 1;
      end
    end
  end

  // monitor: pops the scoreboard on each result handshake
  initial begin : monitor
    int tick = 0;
    rsp_ready = 1'b0;
    forever begin
      @(negedge clk);
      tick++;
      if (rsp_valid && (tick % 2 == 0)) begin
        exp_t e;
        rsp_ready = 1'b1;
        if (exq.size() == 0) begin
          chk(0, "R9 unexpected response", 64'd1, 64'd0);
        end else begin
          e = exq.pop_front();
          chk(rsp_fault == e.fault, {e.tag, " fault"}, 64'(rsp_fault), 64'(e.fault));
          chk(rsp_level == e.lvl, {e.tag, " level"}, 64'(rsp_level), 64'(e.lvl));
          chk(n_rd == e.reads, {e.tag, " reads"}, 64'(n_rd), 64'(e.reads));
          chk(n_wr == e.writes, {e.tag, " writes"}, 64'(n_wr), 64'(e.writes));
          if (e.fault == 2'd0) begin
            chk(rsp_pa == e.pa, {e.tag, " pa"}, 64'(rsp_pa), 64'(e.pa));
            chk(rsp_size == e.size, {e.tag, " size"}, 64'(rsp_size), 64'(e.size));
            chk({rsp_wr, rsp_user, rsp_nx} == {e.wr, e.usr, e.nx}, {e.tag, " perms"},
                64'({rsp_wr, rsp_user, rsp_nx}), 64'({e.wr, e.usr, e.nx}));
          end
        end
      end else begin
        rsp_ready = 1'b0;
      end
    end
  end

  // driver: issues one walk and pushes its expectation
  task automatic walk(input logic [63:0] va, input logic [1:0] acc, input logic usr, input exp_t e);
    @(negedge clk);
    req_va = va; req_acc = acc; req_user = usr; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    n_rd = 0; n_wr = 0; rd_log.delete();
    exq.push_back(e);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R9 busy after accept", 64'(req_ready), 64'd0);
    while (exq.size() != 0) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    chk(0, "watchdog expired", 64'd0, 64'd1);
    finish_run();
  end

  initial begin : stimulus
    logic [63:0] va;
    // main tree
    put(ROOT, 1, 64'(T2) | 64'h7);
    put(T2, 2, 64'(T3) | 64'h7);
    put(T3, 3, 64'(T4) | 64'h7);
    put(T4, 4, 64'(F1) | 64'h7);
    put(T3, 9, E2M);
    // read-only branch
    put(T2, 6, 64'h50000 | 64'h5);
    put(52'h50000, 0, 64'h60000 | 64'h7);
    put(52'h60000, 0, 64'(F2) | 64'h7);
    // supervisor-only branch with 1 GB page
    put(ROOT, 2, 64'h70000 | 64'h3);
    put(52'h70000, 0, E1G);
    // bit 7 at levels 1 and 4
    put(ROOT, 3, 64'h80000 | 64'h87);
    put(52'h80000, 0, 64'h90000 | 64'h7);
    put(52'h90000, 0, 64'hA0000 | 64'h7);
    put(52'hA0000, 0, 64'(F3) | 64'h87);
    // no-execute at the root
    put(ROOT, 4, 64'h8000_0000_000B_0007);
    put(52'hB0000, 0, E1G2);

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R9 reset state",
        64'({req_ready, rsp_valid, mem_req_valid}), 64'b100);

    // R7 four-level walk, first touch sets accessed
    va = mkva(1, 2, 3, 4, 12'hABC);
    walk(va, 2'd0, 1'b1, ok_e("R7 4K read", F1 | 52'hABC, 2'd0, 3'd4, 1, 1, 0, 4, 1));
    chk(rd_log.size() == 4, "R2 read count", 64'(rd_log.size()), 64'd4);
    if (rd_log.size() == 4) begin
      chk(rd_log[0] == slot(ROOT, 1), "R2 level1 address", 64'(rd_log[0]), 64'(slot(ROOT, 1)));
      chk(rd_log[1] == slot(T2, 2), "R2 level2 address", 64'(rd_log[1]), 64'(slot(T2, 2)));
      chk(rd_log[2] == slot(T3, 3), "R2 level3 address", 64'(rd_log[2]), 64'(slot(T3, 3)));
      chk(rd_log[3] == slot(T4, 4), "R2 level4 address", 64'(rd_log[3]), 64'(slot(T4, 4)));
    end
    chk(mrd(slot(T4, 4)) == (64'(F1) | 64'h27), "R8 accessed stored", mrd(slot(T4, 4)), 64'(F1) | 64'h27);
    walk(va, 2'd0, 1'b1, ok_e("R8 no store when unchanged", F1 | 52'hABC, 2'd0, 3'd4, 1, 1, 0, 4, 0));
    walk(va, 2'd1, 1'b1, ok_e("R8 dirty store", F1 | 52'hABC, 2'd0, 3'd4, 1, 1, 0, 4, 1));
    chk(mrd(slot(T4, 4)) == (64'(F1) | 64'h67), "R8 dirty stored", mrd(slot(T4, 4)), 64'(F1) | 64'h67);
    walk(va, 2'd1, 1'b0, ok_e("R8 second write no store", F1 | 52'hABC, 2'd0, 3'd4, 1, 1, 0, 4, 0));

    // R3 not present at level 3 and at level 1
    walk(mkva(1, 2, 5, 0, 0), 2'd0, 1'b0, flt_e("R3 absent level3", 2'd2, 3'd3, 3));
    walk(mkva(7, 0, 0, 0, 0), 2'd0, 1'b0, flt_e("R3 absent level1", 2'd2, 3'd1, 1));

    // R1 canonical check
    walk(64'h0001_0000_0000_0000, 2'd0, 1'b0, flt_e("R1 upper bit set", 2'd1, 3'd0, 0));
    walk(64'hFFFF_0000_0000_1000, 2'd0, 1'b0, flt_e("R1 ones over bit47 clear", 2'd1, 3'd0, 0));
    walk(64'h0000_8000_0000_0000, 2'd0, 1'b0, flt_e("R1 zeros over bit47 set", 2'd1, 3'd0, 0));
    walk(mkva(256, 0, 0, 0, 0), 2'd0, 1'b0, flt_e("R1 high half walked", 2'd2, 3'd1, 1));

    // R5 and R4 on a read-only branch
    va = mkva(1, 6, 0, 0, 12'h010);
    walk(va, 2'd1, 1'b1, flt_e("R5 write to read-only", 2'd3, 3'd4, 4));
    chk(mrd(slot(52'h60000, 0)) == (64'(F2) | 64'h7), "R5 entry untouched after fault",
        mrd(slot(52'h60000, 0)), 64'(F2) | 64'h7);
    walk(va, 2'd0, 1'b1, ok_e("R4 read-only accumulated", F2 | 52'h010, 2'd0, 3'd4, 0, 1, 0, 4, 1));

    // R6 1 GB page on a supervisor branch
    va = mkva(2, 0, 9'h1A5, 9'h0F0, 12'h321);
    walk(va, 2'd0, 1'b1, flt_e("R5 user on supervisor path", 2'd3, 3'd2, 2));
    walk(va, 2'd0, 1'b0, ok_e("R6 1G page", 52'(E1G & 64'h000F_FFFF_C000_0000) | 52'(va & 64'h3FFF_FFFF),
                              2'd2, 3'd2, 1, 0, 0, 2, 1));
    chk(mrd(slot(52'h70000, 0)) == (E1G | 64'h20), "R8 1G accessed stored", mrd(slot(52'h70000, 0)), E1G | 64'h20);

    // R6 2 MB page with no-execute
    va = mkva(1, 2, 9, 9'h155, 12'h777);
    walk(va, 2'd2, 1'b1, flt_e("R5 fetch from no-execute", 2'd3, 3'd3, 3));
    walk(va, 2'd0, 1'b1, ok_e("R6 2M page", 52'(E2M & 64'h000F_FFFF_FFE0_0000) | 52'(va & 64'h1F_FFFF),
                              2'd1, 3'd3, 1, 1, 1, 3, 0));
    walk(va, 2'd1, 1'b1, ok_e("R8 2M dirty store", 52'(E2M & 64'h000F_FFFF_FFE0_0000) | 52'(va & 64'h1F_FFFF),
                              2'd1, 3'd3, 1, 1, 1, 3, 1));
    chk(mrd(slot(T3, 9)) == (E2M | 64'h40), "R8 2M dirty stored", mrd(slot(T3, 9)), E2M | 64'h40);

    // R6 bit 7 has no effect at levels 1 and 4
    walk(mkva(3, 0, 0, 0, 12'h005), 2'd0, 1'b0,
         ok_e("R6 bit7 ignored at level1 and level4", F3 | 52'h005, 2'd0, 3'd4, 1, 1, 0, 4, 1));

    // R4 no-execute from the root reaches a 1 GB page
    va = mkva(4, 0, 3, 0, 0);
    walk(va, 2'd2, 1'b0, flt_e("R4 root no-execute blocks fetch", 2'd3, 3'd2, 2));
    walk(va, 2'd0, 1'b0, ok_e("R4 root no-execute reported", 52'h1_4000_0000 | 52'(va & 64'h3FFF_FFFF),
                              2'd2, 3'd2, 1, 1, 1, 2, 0));

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule